// File: doc/BRIEF.md
# Digit-Serial Radix-4 Booth Recoder

This block turns a multiplier operand that arrives as a stream of binary digits, least significant digit first, into modified-Booth (radix-4) control digits. Every accepted input digit of `DIGIT_W` bits gives `DIGIT_W/2` recoded digits at once. Each recoded digit has a value in {-2, -1, 0, +1, +2} and is carried on three control lines: an active-low zero flag, a negate flag and a double flag. The lowest recoded digit of an input digit needs the top bit of the digit before it. That bit is held in a register between clock cycles and is cleared when a new word starts.

The block also holds the partial-product selectors for one recoded digit-serial multiplier cell. For each recoded digit, a row of 2:1 muxes picks the other operand's digit either as it is (x1) or shifted up by one place (x2). The x2 case takes its lowest bit from the top bit of that operand's lower neighbouring digit. The selected bits are then inverted for negative values and forced to zero for zero values. A correction bit marks where the +1 of the two's-complement negation has to be added. Carry-save accumulation of the rows is done outside this block. All outputs are registered and appear one clock after the digit is accepted.

Top module: `booth_digit_recoder`

## Requirements
- R1: While reset is asserted, and after it until the first accepted digit, `out_valid`, `zero_n`, `neg`, `dbl`, `pp_bits` and `pp_cor` are all 0.
- R2: Recoded digit j of an input digit is taken from the triplet (b[2j+1], b[2j], b[2j-1]), where b[-1] is the overlap bit. The mapping is 000→0, 001→+1, 010→+1, 011→+2, 100→-2, 101→-1, 110→-1, 111→0. On the controls: `zero_n[j]`=1 for a nonzero value, `neg[j]`=1 for a negative value, `dbl[j]`=1 for magnitude 2. For a zero value, `neg[j]` and `dbl[j]` are both 0.
- R3: The overlap bit is the top bit of the previously accepted digit. When `word_start` is high with the accepted digit, the overlap bit is 0 instead.
- R4: A digit is accepted on a rising edge where `in_valid` is 1. Its results and `out_valid`=1 appear on the next rising edge. `out_valid` is 1 after exactly those edges that follow an accepting edge.
- R5: A cycle with `in_valid`=0 changes neither the stored overlap bit nor any result output. Only `out_valid` drops to 0.
- R6: Over a word sent as consecutive digits, with `word_start` on the first digit, the sum of every recoded value times 4^k (k counting recoded digits from 0) equals the word read as a two's-complement number. This holds even when idle cycles are inserted between the digits.
- R7: Partial-product bit k of slice j (`pp_bits[j*DIGIT_W+k]`) is computed from ext = {a_digit, a_low_msb}. It is ext[k+1] for magnitude 1 and ext[k] for magnitude 2, then inverted when the value is negative, and it is 0 when the value is zero.
- R8: `pp_cor[j]` is 1 exactly when recoded digit j is negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input digit present this cycle |
| word_start | input | 1 | Input digit is the least significant digit of a new word |
| b_digit | input | DIGIT_W | Digit of the operand being recoded |
| a_digit | input | DIGIT_W | Digit of the other operand, fed to the selectors |
| a_low_msb | input | 1 | Top bit of the other operand's lower neighbouring digit |
| out_valid | output | 1 | Result outputs were updated by the last accepted digit |
| zero_n | output | DIGIT_W/2 | Per recoded digit: 1 when the value is nonzero |
| neg | output | DIGIT_W/2 | Per recoded digit: value is negative |
| dbl | output | DIGIT_W/2 | Per recoded digit: magnitude is 2 |
| pp_bits | output | DIGIT_W*DIGIT_W/2 | Selected partial-product bits, DIGIT_W per recoded digit |
| pp_cor | output | DIGIT_W/2 | Per recoded digit: +1 correction for a negated row |

## Verification
The case that is hardest to reach from the ports is a word whose digits are separated by idle cycles. In that case the overlap bit has to survive the gaps while the outputs hold still. The stimulus inserts idle cycles at random positions inside words and checks that each rebuilt word still matches its two's-complement value. Directed words made of long runs of ones and alternating patterns exercise the carries across digit boundaries. A word started right after a word ending in a 1 checks that `word_start` masks the stale overlap bit.

// File: rtl/booth_pkg.sv
package booth_pkg;

    // Control triple for one radix-4 recoded digit
    typedef struct packed {
        logic zero_n;   // 1: value nonzero
        logic neg;      // 1: value negative
        logic dbl;      // 1: magnitude two
    } booth_ctrl_t;

    localparam booth_ctrl_t CTRL_ZERO = '{zero_n: 1'b0, neg: 1'b0, dbl: 1'b0};
    localparam booth_ctrl_t CTRL_P1   = '{zero_n: 1'b1, neg: 1'b0, dbl: 1'b0};
    localparam booth_ctrl_t CTRL_P2   = '{zero_n: 1'b1, neg: 1'b0, dbl: 1'b1};
    localparam booth_ctrl_t CTRL_M1   = '{zero_n: 1'b1, neg: 1'b1, dbl: 1'b0};
    localparam booth_ctrl_t CTRL_M2   = '{zero_n: 1'b1, neg: 1'b1, dbl: 1'b1};

endpackage

// File: rtl/booth_triplet.sv
module booth_triplet
    import booth_pkg::*;
(
    input  logic [2:0]  trip,
    output booth_ctrl_t ctrl
);

    always_comb begin
        unique case (trip)
            3'b001, 3'b010: ctrl = CTRL_P1;
            3'b011:         ctrl = CTRL_P2;
            3'b100:         ctrl = CTRL_M2;
            3'b101, 3'b110: ctrl = CTRL_M1;
            default:        ctrl = CTRL_ZERO;
        endcase
    end

endmodule

// File: rtl/booth_pp_mux.sv
module booth_pp_mux
    import booth_pkg::*;
#(
    parameter int DIGIT_W = 4
) (
    input  booth_ctrl_t        ctrl,
    input  logic [DIGIT_W-1:0] opd,
    input  logic               opd_low_msb,
    output logic [DIGIT_W-1:0] pp,
    output logic               cor
);

    logic [DIGIT_W:0] ext;
    assign ext = {opd, opd_low_msb};

    for (genvar k = 0; k < DIGIT_W; k++) begin : g_bit
        logic pick;
        // x2 takes the bit one place lower
        assign pick  = ctrl.dbl ? ext[k] : ext[k+1];
        assign pp[k] = ctrl.zero_n & (pick ^ ctrl.neg);
    end

    assign cor = ctrl.zero_n & ctrl.neg;

endmodule

// File: rtl/booth_digit_recoder.sv
module booth_digit_recoder
    import booth_pkg::*;
#(
    parameter  int DIGIT_W = 4,
    localparam int RD      = DIGIT_W / 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  word_start,
    input  logic [DIGIT_W-1:0]    b_digit,
    input  logic [DIGIT_W-1:0]    a_digit,
    input  logic                  a_low_msb,
    output logic                  out_valid,
    output logic [RD-1:0]         zero_n,
    output logic [RD-1:0]         neg,
    output logic [RD-1:0]         dbl,
    output logic [RD*DIGIT_W-1:0] pp_bits,
    output logic [RD-1:0]         pp_cor
);

    typedef struct packed {
        logic                          valid;
        logic                          ovl;
        booth_ctrl_t [RD-1:0]          ctrl;
        logic [RD-1:0][DIGIT_W-1:0]    pp;
        logic [RD-1:0]                 cor;
    } state_t;

    state_t st_d, st_q;

    // Overlap bit seen by the lowest triplet
    logic               ovl_eff;
    logic [DIGIT_W:0]   b_ext;

    assign ovl_eff = word_start ? 1'b0 : st_q.ovl;
    assign b_ext   = {b_digit, ovl_eff};

    booth_ctrl_t        ctrl_c [RD];
    logic [DIGIT_W-1:0] pp_c   [RD];
    logic               cor_c  [RD];

    for (genvar j = 0; j < RD; j++) begin : g_slice
        booth_triplet i_trip (
            .trip (b_ext[2*j+2:2*j]),
            .ctrl (ctrl_c[j])
        );

        booth_pp_mux #(.DIGIT_W(DIGIT_W)) i_mux (
            .ctrl        (ctrl_c[j]),
            .opd         (a_digit),
            .opd_low_msb (a_low_msb),
            .pp          (pp_c[j]),
            .cor         (cor_c[j])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.ovl = b_digit[DIGIT_W-1];
            for (int j = 0; j < RD; j++) begin
                st_d.ctrl[j] = ctrl_c[j];
                st_d.pp[j]   = pp_c[j];
                st_d.cor[j]  = cor_c[j];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;

    for (genvar j = 0; j < RD; j++) begin : g_out
        assign zero_n[j]                     = st_q.ctrl[j].zero_n;
        assign neg[j]                        = st_q.ctrl[j].neg;
        assign dbl[j]                        = st_q.ctrl[j].dbl;
        assign pp_bits[j*DIGIT_W +: DIGIT_W] = st_q.pp[j];
        assign pp_cor[j]                     = st_q.cor[j];
    end

endmodule

// File: rtl/booth_digit_recoder_chk.sv
module booth_digit_recoder_chk #(
    parameter  int DIGIT_W = 4,
    localparam int RD      = DIGIT_W / 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic                  word_start,
    input logic [DIGIT_W-1:0]    b_digit,
    input logic [DIGIT_W-1:0]    a_digit,
    input logic                  a_low_msb,
    input logic                  out_valid,
    input logic [RD-1:0]         zero_n,
    input logic [RD-1:0]         neg,
    input logic [RD-1:0]         dbl,
    input logic [RD*DIGIT_W-1:0] pp_bits,
    input logic [RD-1:0]         pp_cor
);

    a_r4_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r4_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(zero_n) && $stable(neg) && $stable(dbl)
                       && $stable(pp_bits) && $stable(pp_cor)));

    // R3: word start hides the old overlap bit from the low triplet
    a_r3_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && word_start && b_digit[1:0] == 2'b00) |=> !zero_n[0]);

    a_r3_start_minus2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && word_start && b_digit[1:0] == 2'b10) |=> (neg[0] && dbl[0]));

    for (genvar j = 0; j < RD; j++) begin : g_chk
        a_r2_zero_clean: assert property (@(posedge clk) disable iff (!rst_n)
            !zero_n[j] |-> (!neg[j] && !dbl[j]));

        a_r7_zero_row: assert property (@(posedge clk) disable iff (!rst_n)
            !zero_n[j] |-> (pp_bits[j*DIGIT_W +: DIGIT_W] == '0 && !pp_cor[j]));
    end

endmodule

bind booth_digit_recoder booth_digit_recoder_chk #(.DIGIT_W(DIGIT_W)) i_chk (.*);

// File: tb/test_booth_digit_recoder.sv
module test_booth_digit_recoder;

    localparam int W  = 4;
    localparam int RD = W / 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            word_start = 1'b0;
    logic [W-1:0]    b_digit = '0;
    logic [W-1:0]    a_digit = '0;
    logic            a_low_msb = 1'b0;
    logic            out_valid;
    logic [RD-1:0]   zero_n, neg, dbl, pp_cor;
    logic [RD*W-1:0] pp_bits;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic   m_ovl = 1'b0;
    longint acc;
    int     sh;

    always #2.5 clk = ~clk;

    booth_digit_recoder #(.DIGIT_W(W)) i_booth_digit_recoder (
        .clk, .rst_n, .in_valid, .word_start, .b_digit, .a_digit, .a_low_msb,
        .out_valid, .zero_n, .neg, .dbl, .pp_bits, .pp_cor
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rec_val(input logic [2:0] t);
        case (t)
            3'b001, 3'b010: return 1;
            3'b011:         return 2;
            3'b100:         return -2;
            3'b101, 3'b110: return -1;
            default:        return 0;
        endcase
    endfunction

    function automatic int pp_model(input int v, input logic [3:0] a, input logic lo);
        int sel;
        if (v == 0) return 0;
        sel = (v == 2 || v == -2) ? (((int'(a) << 1) | int'(lo)) & 15) : int'(a);
        if (v < 0) sel = (~sel) & 15;
        return sel;
    endfunction

    // Drive one digit, wait one cycle, check the registered results
    task automatic send_digit(input logic [3:0] b, input logic st,
                              input logic [3:0] a, input logic lo);
        logic [4:0] ext;
        int v [RD];
        in_valid   = 1'b1;
        word_start = st;
        b_digit    = b;
        a_digit    = a;
        a_low_msb  = lo;
        ext = {b, (st ? 1'b0 : m_ovl)};
        for (int j = 0; j < RD; j++) v[j] = rec_val(ext[2*j +: 3]);
        @(negedge clk);
        chk("R4 out_valid", out_valid, 1);
        for (int j = 0; j < RD; j++) begin
            chk("R2/R3 zero_n", zero_n[j], v[j] != 0);
            chk("R2 neg",       neg[j],    v[j] < 0);
            chk("R2 dbl",       dbl[j],    v[j] == 2 || v[j] == -2);
            chk("R7 pp_bits",   pp_bits[j*W +: W], pp_model(v[j], a, lo));
            chk("R8 pp_cor",    pp_cor[j], v[j] < 0);
            acc += longint'(v[j]) <<< sh;
            sh  += 2;
        end
        m_ovl = b[3];
    endtask

    task automatic idle_cycle();
        logic [RD-1:0]   z0, n0, d0, c0;
        logic [RD*W-1:0] p0;
        z0 = zero_n; n0 = neg; d0 = dbl; c0 = pp_cor; p0 = pp_bits;
        in_valid   = 1'b0;
        word_start = 1'b0;
        b_digit    = 4'($urandom);
        a_digit    = 4'($urandom);
        @(negedge clk);
        chk("R4 out_valid low", out_valid, 0);
        chk("R5 hold ctrl", {zero_n, neg, dbl, pp_cor}, {z0, n0, d0, c0});
        chk("R5 hold pp", pp_bits, p0);
    endtask

    task automatic send_word(input logic [15:0] w, input int gap_pct);
        acc = 0;
        sh  = 0;
        for (int d = 0; d < 4; d++) begin
            if (d != 0 && int'($urandom % 100) < gap_pct) idle_cycle();
            send_digit(w[4*d +: 4], d == 0, 4'($urandom), 1'($urandom));
        end
        chk("R6 word sum", acc, longint'($signed(w)));
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        chk("R1 out_valid", out_valid, 0);
        chk("R1 ctrl", {zero_n, neg, dbl}, 0);
        chk("R1 pp", pp_bits, 0);
        chk("R1 cor", pp_cor, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {out_valid, zero_n, pp_bits}, 0);

        send_word(16'h0000, 0);
        send_word(16'hFFFF, 0);
        send_word(16'h8000, 0);
        send_word(16'h7FFF, 0);
        send_word(16'hAAAA, 0);
        send_word(16'h5555, 0);
        send_word(16'h9999, 100);
        // R3: previous word ended with top bit 1; new word must not see it
        send_word(16'hF0F8, 0);
        send_word(16'h0004, 50);
        idle_cycle();
        send_word(16'h8002, 0);

        for (int n = 0; n < 400; n++) begin
            send_word(16'($urandom), 30);
            if ($urandom % 6 == 0) idle_cycle();
        end

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule